// File: doc/BRIEF.md
# Status-Flag and Miscellaneous Execute Unit

This block is the execute-stage slice of a small 32-bit processor that handles the flag and miscellaneous operations. It holds the user-visible status bits T, S, M and Q. It also holds two special registers: the global-base register (GBR) and the procedure-return register (PR). Each cycle it takes a pre-decoded operation code, the raw 16-bit instruction word, two 32-bit source values, an 8-bit immediate and the program counter of the instruction.

It produces its outputs combinationally in the same cycle:
- a destination write value and write enable, plus a flag that steers the write to r0;
- a trap request and a zero-extended trap code;
- an illegal-instruction indication.

Architectural state changes only on a rising clock edge while `valid_i` is high and the instruction is legal. Opcode decoding, memory access, multiply/divide and trap servicing live elsewhere. This unit only raises the requests.

Top module: `flag_misc_exec`

## Requirements
- R1: `op_i` encoding is 0 NOP, 1 CLRT, 2 SETT, 3 CLRS, 4 SETS, 5 MOVT, 6 SWAPB, 7 SWAPW, 8 XTRCT, 9 MOVA, 10 TRAPA, 11 PREF, 12 STC_GBR, 13 LDC_GBR, 14 STC_PR, 15 LDC_PR. No operation alters M or Q, which keep their reset value.
- R2: CLRT/SETT clear/set T, and CLRS/SETS clear/set S, visible on `t_o`/`s_o` after the next rising edge. None of them asserts `wr_en_o`.
- R3: MOVT asserts `wr_en_o` with `wr_data_o` equal to T zero-extended (0 or 1). No operation loads T from a register.
- R4: SWAPB writes `rm_i` with bits [15:8] and [7:0] exchanged and bits [31:16] unchanged.
- R5: SWAPW writes `rm_i` with its 16-bit halves exchanged.
- R6: XTRCT writes `{rn_i[15:0], rm_i[31:16]}`, where `rn_i` is the old destination value.
- R7: MOVA asserts `wr_en_o` and `wr_r0_o` with `wr_data_o = ((pc_i + 4) & ~3) + imm_i*4`. The largest offset is 1020. No other operation asserts `wr_r0_o`.
- R8: TRAPA asserts `trap_o` with `trap_code_o` equal to `imm_i` zero-extended, and does not write back.
- R9: When `valid_i` is high and `insn_i` is all zeros, `illegal_o` is asserted. Whatever `op_i` says, there is then no writeback, no trap and no state change.
- R10: LDC_GBR/LDC_PR load `rm_i` into GBR/PR at the next edge. STC_GBR/STC_PR write the current GBR/PR value to the destination.
- R11: PREF and NOP produce no writeback, no trap, no illegal indication and no state change, for any address.
- R12: Synchronous active-high reset clears T, S, M, Q, GBR and PR. While `valid_i` is low, no output request is raised and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Pre-decoded operation code (R1) |
| insn_i | input | 16 | Raw instruction word, used for the illegal check |
| rm_i | input | 32 | Source register value |
| rn_i | input | 32 | Old destination register value |
| imm_i | input | 8 | Unsigned immediate / displacement |
| pc_i | input | 32 | Address of the instruction |
| wr_en_o | output | 1 | Destination write enable |
| wr_r0_o | output | 1 | Write goes to r0 instead of the encoded destination |
| wr_data_o | output | 32 | Destination write value |
| trap_o | output | 1 | Trap request |
| trap_code_o | output | 32 | Zero-extended trap code |
| illegal_o | output | 1 | Illegal-instruction indication |
| t_o | output | 1 | T flag |
| s_o | output | 1 | S flag |
| m_o | output | 1 | M flag |
| q_o | output | 1 | Q flag |
| gbr_o | output | 32 | Global-base register |
| pr_o | output | 32 | Procedure-return register |

## Verification
The bench targets these corner cases, each with the failure it would expose:

- **All-zero word under a state-changing op.** The word is driven with opcodes such as SETT, LDC or TRAPA. A unit that trusted the opcode would flip T, load GBR or raise a trap on what must be a fault.
- **MOVA at the extremes.** MOVA is driven with a displacement of 255 and program counters whose low bits are set. A missing alignment, missing scaling or wrong +4 base gives an address off by 1 to 1020.
- **XTRCT with distinct patterns.** Distinct values in both operands catch a swapped operand order.
- **SWAPB with a busy upper half.** A non-zero upper half catches a swap that disturbs bits [31:16].
- **Strobe low.** Random operations with the strobe low catch state that updates or requests that fire without `valid_i`.

// File: rtl/flag_misc_pkg.sv
package flag_misc_pkg;

    localparam int XLEN   = 32;
    localparam int HALF   = XLEN / 2;
    localparam int INSN_W = 16;
    localparam int IMM_W  = 8;
    localparam int OP_W   = 4;
    localparam int DISP_SHIFT = 2;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 4'd0,
        OP_CLRT    = 4'd1,
        OP_SETT    = 4'd2,
        OP_CLRS    = 4'd3,
        OP_SETS    = 4'd4,
        OP_MOVT    = 4'd5,
        OP_SWAPB   = 4'd6,
        OP_SWAPW   = 4'd7,
        OP_XTRCT   = 4'd8,
        OP_MOVA    = 4'd9,
        OP_TRAPA   = 4'd10,
        OP_PREF    = 4'd11,
        OP_STC_GBR = 4'd12,
        OP_LDC_GBR = 4'd13,
        OP_STC_PR  = 4'd14,
        OP_LDC_PR  = 4'd15
    } op_e;

    typedef struct packed {
        logic            t;
        logic            s;
        logic            m;
        logic            q;
        logic [XLEN-1:0] gbr;
        logic [XLEN-1:0] pr;
    } arch_state_t;

    typedef struct packed {
        logic            wr_t;
        logic            t_val;
        logic            wr_s;
        logic            s_val;
        logic            ld_gbr;
        logic            ld_pr;
        logic [XLEN-1:0] ld_val;
    } state_upd_t;

    typedef struct packed {
        logic            wr_en;
        logic            wr_r0;
        logic [XLEN-1:0] wr_data;
        logic            trap;
        logic [XLEN-1:0] trap_code;
    } exec_res_t;

    function automatic logic [XLEN-1:0] swap_low_bytes(input logic [XLEN-1:0] v);
        return {v[XLEN-1:HALF], v[7:0], v[15:8]};
    endfunction

    function automatic logic [XLEN-1:0] swap_halves(input logic [XLEN-1:0] v);
        return {v[HALF-1:0], v[XLEN-1:HALF]};
    endfunction

    function automatic logic [XLEN-1:0] mid_extract(input logic [XLEN-1:0] hi,
                                                    input logic [XLEN-1:0] lo);
        return {hi[HALF-1:0], lo[XLEN-1:HALF]};
    endfunction

    function automatic logic [XLEN-1:0] pc_rel_addr(input logic [XLEN-1:0] pc,
                                                    input logic [IMM_W-1:0] disp);
        logic [XLEN-1:0] base;
        logic [XLEN-1:0] off;
        base = {pc[XLEN-1:DISP_SHIFT], {DISP_SHIFT{1'b0}}} + XLEN'(4);
        off  = {{(XLEN-IMM_W-DISP_SHIFT){1'b0}}, disp, {DISP_SHIFT{1'b0}}};
        return base + off;
    endfunction

endpackage

// File: rtl/fm_decode.sv
module fm_decode
    import flag_misc_pkg::*;
(
    input  logic              valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [INSN_W-1:0] insn_i,
    output logic              go_o,
    output logic              illegal_o,
    output op_e               op_o
);
    logic zero_word;

    always_comb begin
        zero_word = (insn_i == '0);
        illegal_o = valid_i && zero_word;
        go_o      = valid_i && !zero_word;
        op_o      = op_e'(op_i);
    end
endmodule

// File: rtl/fm_datapath.sv
module fm_datapath
    import flag_misc_pkg::*;
(
    input  logic              go_i,
    input  op_e               op_i,
    input  logic [XLEN-1:0]   rm_i,
    input  logic [XLEN-1:0]   rn_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [XLEN-1:0]   pc_i,
    input  arch_state_t       cur_i,
    output exec_res_t         res_o,
    output state_upd_t        upd_o
);
    always_comb begin
        res_o = '0;
        upd_o = '0;
        upd_o.ld_val = rm_i;
        if (go_i) begin
            unique case (op_i)
                OP_CLRT: begin upd_o.wr_t = 1'b1; upd_o.t_val = 1'b0; end
                OP_SETT: begin upd_o.wr_t = 1'b1; upd_o.t_val = 1'b1; end
                OP_CLRS: begin upd_o.wr_s = 1'b1; upd_o.s_val = 1'b0; end
                OP_SETS: begin upd_o.wr_s = 1'b1; upd_o.s_val = 1'b1; end
                OP_MOVT: begin
                    res_o.wr_en   = 1'b1;
                    res_o.wr_data = {{(XLEN-1){1'b0}}, cur_i.t};
                end
                OP_SWAPB: begin
                    res_o.wr_en   = 1'b1;
                    res_o.wr_data = swap_low_bytes(rm_i);
                end
                OP_SWAPW: begin
                    res_o.wr_en   = 1'b1;
                    res_o.wr_data = swap_halves(rm_i);
                end
                OP_XTRCT: begin
                    res_o.wr_en   = 1'b1;
                    res_o.wr_data = mid_extract(rn_i, rm_i);
                end
                OP_MOVA: begin
                    res_o.wr_en   = 1'b1;
                    res_o.wr_r0   = 1'b1;
                    res_o.wr_data = pc_rel_addr(pc_i, imm_i);
                end
                OP_TRAPA: begin
                    res_o.trap      = 1'b1;
                    res_o.trap_code = {{(XLEN-IMM_W){1'b0}}, imm_i};
                end
                OP_STC_GBR: begin
                    res_o.wr_en   = 1'b1;
                    res_o.wr_data = cur_i.gbr;
                end
                OP_STC_PR: begin
                    res_o.wr_en   = 1'b1;
                    res_o.wr_data = cur_i.pr;
                end
                OP_LDC_GBR: upd_o.ld_gbr = 1'b1;
                OP_LDC_PR:  upd_o.ld_pr  = 1'b1;
                default: ;  // NOP, PREF: no effect
            endcase
        end
    end
endmodule

// File: rtl/fm_state.sv
module fm_state
    import flag_misc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  state_upd_t  upd_i,
    output arch_state_t cur_o
);
    arch_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (upd_i.wr_t)   st_q.t   <= upd_i.t_val;
            if (upd_i.wr_s)   st_q.s   <= upd_i.s_val;
            if (upd_i.ld_gbr) st_q.gbr <= upd_i.ld_val;
            if (upd_i.ld_pr)  st_q.pr  <= upd_i.ld_val;
        end
    end

    assign cur_o = st_q;
endmodule

// File: rtl/flag_misc_exec.sv
module flag_misc_exec
    import flag_misc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                valid_i,
    input  logic [OP_W-1:0]     op_i,
    input  logic [INSN_W-1:0]   insn_i,
    input  logic [XLEN-1:0]     rm_i,
    input  logic [XLEN-1:0]     rn_i,
    input  logic [IMM_W-1:0]    imm_i,
    input  logic [XLEN-1:0]     pc_i,
    output logic                wr_en_o,
    output logic                wr_r0_o,
    output logic [XLEN-1:0]     wr_data_o,
    output logic                trap_o,
    output logic [XLEN-1:0]     trap_code_o,
    output logic                illegal_o,
    output logic                t_o,
    output logic                s_o,
    output logic                m_o,
    output logic                q_o,
    output logic [XLEN-1:0]     gbr_o,
    output logic [XLEN-1:0]     pr_o
);
    logic        go;
    op_e         op;
    arch_state_t cur;
    exec_res_t   res;
    state_upd_t  upd;

    fm_decode i_dec (
        .valid_i   (valid_i),
        .op_i      (op_i),
        .insn_i    (insn_i),
        .go_o      (go),
        .illegal_o (illegal_o),
        .op_o      (op)
    );

    fm_datapath i_dp (
        .go_i   (go),
        .op_i   (op),
        .rm_i   (rm_i),
        .rn_i   (rn_i),
        .imm_i  (imm_i),
        .pc_i   (pc_i),
        .cur_i  (cur),
        .res_o  (res),
        .upd_o  (upd)
    );

    fm_state i_st (
        .clk   (clk),
        .rst   (rst),
        .upd_i (upd),
        .cur_o (cur)
    );

    assign wr_en_o     = res.wr_en;
    assign wr_r0_o     = res.wr_r0;
    assign wr_data_o   = res.wr_data;
    assign trap_o      = res.trap;
    assign trap_code_o = res.trap_code;
    assign t_o         = cur.t;
    assign s_o         = cur.s;
    assign m_o         = cur.m;
    assign q_o         = cur.q;
    assign gbr_o       = cur.gbr;
    assign pr_o        = cur.pr;
endmodule

// File: rtl/flag_misc_exec_chk.sv
module flag_misc_exec_chk
    import flag_misc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                valid_i,
    input logic [OP_W-1:0]     op_i,
    input logic [INSN_W-1:0]   insn_i,
    input logic [XLEN-1:0]     rm_i,
    input logic [XLEN-1:0]     rn_i,
    input logic [IMM_W-1:0]    imm_i,
    input logic [XLEN-1:0]     pc_i,
    input logic                wr_en_o,
    input logic                wr_r0_o,
    input logic [XLEN-1:0]     wr_data_o,
    input logic                trap_o,
    input logic [XLEN-1:0]     trap_code_o,
    input logic                illegal_o,
    input logic                t_o,
    input logic                s_o,
    input logic                m_o,
    input logic                q_o,
    input logic [XLEN-1:0]     gbr_o,
    input logic [XLEN-1:0]     pr_o
);
    logic legal_go;
    assign legal_go = valid_i && (insn_i != '0);

    p_mq_hold_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(m_o) && $stable(q_o));

    p_sett_r2: assert property (@(posedge clk) disable iff (rst)
        legal_go && op_i == OP_SETT |=> t_o);

    p_clrs_r2: assert property (@(posedge clk) disable iff (rst)
        legal_go && op_i == OP_CLRS |=> !s_o);

    p_movt_range_r3: assert property (@(posedge clk) disable iff (rst)
        legal_go && op_i == OP_MOVT |-> wr_en_o && wr_data_o == {{(XLEN-1){1'b0}}, t_o});

    p_r0_only_mova_r7: assert property (@(posedge clk) disable iff (rst)
        wr_r0_o |-> wr_en_o && op_i == OP_MOVA);

    p_trap_nowb_r8: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> !wr_en_o && trap_code_o[XLEN-1:IMM_W] == '0);

    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> !wr_en_o && !trap_o);

    p_illegal_hold_r9: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> $stable(t_o) && $stable(s_o) && $stable(gbr_o) && $stable(pr_o));

    p_ldc_gbr_r10: assert property (@(posedge clk) disable iff (rst)
        legal_go && op_i == OP_LDC_GBR |=> gbr_o == $past(rm_i));

    p_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !valid_i |-> !wr_en_o && !trap_o && !illegal_o);

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(t_o) && $stable(s_o) && $stable(gbr_o) && $stable(pr_o));
endmodule

bind flag_misc_exec flag_misc_exec_chk i_chk (.*);

// File: tb/test_flag_misc_exec.sv
module test_flag_misc_exec;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [3:0]  op_i;
    logic [15:0] insn_i;
    logic [31:0] rm_i, rn_i, pc_i;
    logic [7:0]  imm_i;
    logic        wr_en_o, wr_r0_o, trap_o, illegal_o, t_o, s_o, m_o, q_o;
    logic [31:0] wr_data_o, trap_code_o, gbr_o, pr_o;

    int checks = 0;
    int errors = 0;
    logic        m_t, m_s;
    logic [31:0] m_gbr, m_pr;

    always #5 clk = ~clk;

    flag_misc_exec i_flag_misc_exec (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd1, 4'd2, 4'd3, 4'd4: return "R2";
            4'd5:  return "R3";
            4'd6:  return "R4";
            4'd7:  return "R5";
            4'd8:  return "R6";
            4'd9:  return "R7";
            4'd10: return "R8";
            4'd0, 4'd11: return "R11";
            default: return "R10";
        endcase
    endfunction

    // Drive one operation, check same-cycle outputs, then check state after the edge.
    task automatic do_op(input logic v, input logic [3:0] op, input logic [15:0] insn,
                         input logic [31:0] rm, input logic [31:0] rn,
                         input logic [7:0] imm, input logic [31:0] pc);
        logic        go, e_we, e_r0, e_trap;
        logic [31:0] e_data, e_code, base;
        string       rq;
        @(negedge clk);
        valid_i = v; op_i = op; insn_i = insn; rm_i = rm; rn_i = rn; imm_i = imm; pc_i = pc;
        #1;
        go = v && (insn != 16'h0000);
        rq = !v ? "R12" : (!go ? "R9" : req_of(op));
        e_we = 0; e_r0 = 0; e_trap = 0; e_data = 0; e_code = 0;
        if (go) begin
            case (op)
                4'd5:  begin e_we = 1; e_data = {31'd0, m_t}; end
                4'd6:  begin e_we = 1; e_data = {rm[31:24], rm[23:16], rm[7:0], rm[15:8]}; end
                4'd7:  begin e_we = 1; e_data = {rm[15:0], rm[31:16]}; end
                4'd8:  begin e_we = 1; e_data = (rn << 16) | (rm >> 16); end
                4'd9:  begin
                    base = (pc + 32'd4) & 32'hFFFF_FFFC;
                    e_we = 1; e_r0 = 1; e_data = base + 32'(imm) * 32'd4;
                end
                4'd10: begin e_trap = 1; e_code = 32'(imm); end
                4'd12: begin e_we = 1; e_data = m_gbr; end
                4'd14: begin e_we = 1; e_data = m_pr; end
                default: ;
            endcase
        end
        chk("R9", "illegal", 32'(illegal_o), 32'(v && insn == 16'h0000));
        chk(rq, "wr_en", 32'(wr_en_o), 32'(e_we));
        chk(rq, "wr_r0", 32'(wr_r0_o), 32'(e_r0));
        if (e_we) chk(rq, "wr_data", wr_data_o, e_data);
        chk(rq, "trap", 32'(trap_o), 32'(e_trap));
        if (e_trap) chk(rq, "trap_code", trap_code_o, e_code);
        if (go) begin
            case (op)
                4'd1:  m_t = 0;
                4'd2:  m_t = 1;
                4'd3:  m_s = 0;
                4'd4:  m_s = 1;
                4'd13: m_gbr = rm;
                4'd15: m_pr = rm;
                default: ;
            endcase
        end
        @(posedge clk); #1;
        chk(rq, "t", 32'(t_o), 32'(m_t));
        chk(rq, "s", 32'(s_o), 32'(m_s));
        chk(rq, "gbr", gbr_o, m_gbr);
        chk(rq, "pr", pr_o, m_pr);
        chk("R1", "m,q", {30'd0, m_o, q_o}, 32'd0);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; valid_i = 0; op_i = 0; insn_i = 16'h1; rm_i = 0; rn_i = 0; imm_i = 0; pc_i = 0;
        m_t = 0; m_s = 0; m_gbr = 0; m_pr = 0;
        // dirty the state, then check that reset clears it (R12)
        repeat (2) @(posedge clk);
        rst = 0;
        do_op(1, 4'd2, 16'h0018, 0, 0, 0, 0);
        do_op(1, 4'd13, 16'h401E, 32'hDEAD_BEEF, 0, 0, 0);
        @(negedge clk); rst = 1; valid_i = 0;
        @(posedge clk); #1;
        m_t = 0; m_s = 0; m_gbr = 0; m_pr = 0;
        chk("R12", "reset t", 32'(t_o), 0);
        chk("R12", "reset gbr", gbr_o, 0);
        chk("R12", "reset s,m,q,pr", {29'd0, s_o, m_o, q_o} | pr_o, 0);
        @(negedge clk); rst = 0;

        // directed corners
        do_op(1, 4'd9, 16'hC7FF, 0, 0, 8'hFF, 32'h0000_1003);        // R7 max disp, misaligned pc
        do_op(1, 4'd9, 16'hC700, 0, 0, 8'h00, 32'hFFFF_FFFE);        // R7 wrap
        do_op(1, 4'd8, 16'h2D8D, 32'h1122_3344, 32'h5566_7788, 0, 0); // R6
        do_op(1, 4'd6, 16'h6D18, 32'hA5C3_1234, 0, 0, 0);            // R4 busy upper half
        do_op(1, 4'd7, 16'h6D19, 32'hA5C3_1234, 0, 0, 0);            // R5
        do_op(1, 4'd10, 16'hC3FF, 0, 0, 8'hFF, 0);                   // R8
        do_op(1, 4'd2, 16'h0000, 0, 0, 0, 0);                        // R9 SETT as zero word
        do_op(1, 4'd13, 16'h0000, 32'h1234_5678, 0, 0, 0);           // R9 LDC as zero word
        do_op(1, 4'd10, 16'h0000, 0, 0, 8'h42, 0);                   // R9 trap as zero word
        do_op(1, 4'd11, 16'h0083, 32'hFFFF_FFFF, 0, 0, 0);           // R11 PREF odd addr
        do_op(1, 4'd15, 16'h402A, 32'hCAFE_0001, 0, 0, 0);           // R10
        do_op(1, 4'd14, 16'h002A, 0, 0, 0, 0);                       // R10
        do_op(1, 4'd4, 16'h0058, 0, 0, 0, 0);                        // R2
        do_op(0, 4'd3, 16'h0048, 0, 0, 0, 0);                        // R12 strobe low
        do_op(1, 4'd5, 16'h0029, 0, 0, 0, 0);                        // R3

        for (int i = 0; i < 3000; i++) begin
            logic [15:0] w;
            w = ($urandom % 12 == 0) ? 16'h0000 : 16'($urandom | 1);
            do_op(($urandom % 8) != 0, 4'($urandom), w, $urandom, $urandom,
                  8'($urandom), $urandom);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule